// File: doc/BRIEF.md
# Auto-Increment Packet Access Port

This block lets a host reach packet buffer memory indirectly, through a pointer register and a shared data port that can be used one byte or one 16-bit word at a time. A pointer write names the target packet and sets its parameters. Bit 15 of the pointer chooses which packet is accessed: the one at the head of the receive queue, or the one held in the transmit packet-number register. Bit 14 turns on automatic advance of the offset. Bit 13 puts the port in read mode. Bits 10:0 give the byte offset within the packet. Bits 12:11 are ignored.

The byte address sent to memory is the chosen packet's page number times 256, plus the offset, taken modulo the memory size of 2^(PG_W+8) bytes. In write mode, each accepted data write goes straight to memory in the same cycle. In read mode, a pointer write starts a prefetch, so the first host read finds its data already waiting. Each read that advances the offset starts the next prefetch.

Packets in the buffer start with a 16-bit status word at offset 0. An 11-bit byte count follows at offset 2. The packet ends with a control byte in which bit 5 marks an odd length and bit 4 asks for CRC insertion. The host walks through these fields with the same port. The port itself gives them no special meaning.

The read-side sequencer has four states:
- IDLE: no prefetch is active.
- FETCH: a memory read is issued.
- WAIT: the memory returns data, which is captured.
- HOLD: the data is valid and `rd_valid` is high.

Its transitions are:
- pointer-write-read: any state goes to FETCH.
- pointer-write-write: any state goes to IDLE.
- issue: FETCH goes to WAIT.
- capture: WAIT goes to HOLD.
- consume-advance: HOLD goes to FETCH on a host read with auto-increment on.
- consume-stay: HOLD stays in HOLD on a host read with auto-increment off.

Top module: `pap_port`

## Requirements
- R1: After reset, `rd_valid`, `mem_re` and `mem_we` are all 0.
- R2: `mem_addr` equals (page × 256 + offset) mod 2^(PG_W+8). The page is `rx_head_pg` when pointer bit 15 is 1, and `tx_pkt_pg` when it is 0.
- R3: In write mode (pointer bit 13 = 0), a `data_we` pulse raises `mem_we` in the same cycle. `mem_wdata` equals `data_wdata`, and `mem_wide` equals `data_word`: 1 stores two bytes, 0 stores only the low byte.
- R4: With pointer bit 14 set, the offset advances by 2 after a word access and by 1 after a byte access. With bit 14 clear, the offset does not change.
- R5: The offset is 11 bits wide and wraps from 2047 to 0.
- R6: In read mode (pointer bit 13 = 1), `rd_valid` goes low in the cycle after a pointer write and rises two cycles later. At that point `data_rdata` holds the memory content at the pointer's address.
- R7: A host read in HOLD with auto-increment on drops `rd_valid` in the next cycle and refetches at the new offset. With auto-increment off, `rd_valid` and the held data stay unchanged.
- R8: A word read returns {byte at address+1, byte at address}. A byte read returns the byte at the address in bits 7:0, with bits 15:8 = 0.
- R9: When a pointer write and a data access fall in the same cycle, the pointer write wins. No memory write happens and the new offset is not advanced.
- R10: A `data_we` in read mode is ignored: `mem_we` stays 0, and memory reads and writes are never issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_we | input | 1 | Pointer register write strobe |
| ptr_wdata | input | 16 | Pointer value (bit 15 source, bit 14 auto-increment, bit 13 read, bits 10:0 offset) |
| data_we | input | 1 | Data port write strobe |
| data_re | input | 1 | Data port read strobe (consumes the held data) |
| data_word | input | 1 | 1 = word access, 0 = byte access |
| data_wdata | input | 16 | Data port write value |
| data_rdata | output | 16 | Data port read value |
| rd_valid | output | 1 | Prefetched read data is held and valid |
| rx_head_pg | input | PG_W | Page of the packet at the receive queue head |
| tx_pkt_pg | input | PG_W | Page of the packet in the packet-number register |
| mem_addr | output | PG_W+8 | Buffer byte address |
| mem_re | output | 1 | Buffer read request (data returned one cycle later) |
| mem_we | output | 1 | Buffer write strobe |
| mem_wide | output | 1 | Write stores two bytes when 1 |
| mem_wdata | output | 16 | Buffer write data |
| mem_rdata | input | 16 | Buffer read data, {byte at addr+1, byte at addr} |

## Verification
A pointer write and a data access can land in the same cycle. Both then compete for the offset register and the memory strobes. The bench drives `ptr_we` together with `data_we` while in write mode, and together with `data_re` while read data is held. It then judges the result at the ports: `mem_we` must stay low, and the next write or refetch must use the freshly loaded offset, not an advanced one. Address and data checks run over both packet sources, several pages, offsets at the wrap edge and both access widths. All expected values come from page × 256 + offset arithmetic.

// File: rtl/pap_pkg.sv
package pap_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_HOLD
    } pap_state_e;

    localparam int PTR_SRC_BIT = 15;
    localparam int PTR_INC_BIT = 14;
    localparam int PTR_RD_BIT  = 13;
    localparam int DATA_W      = 16;
endpackage

// File: rtl/pap_ptr_reg.sv
module pap_ptr_reg
    import pap_pkg::*;
#(
    parameter int OFF_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_we,
    input  logic [15:0]       ptr_wdata,
    input  logic              adv,
    input  logic              adv_word,
    output logic              sel_rx,
    output logic              autoinc,
    output logic              rd_mode,
    output logic [OFF_W-1:0]  offset
);
    localparam logic [OFF_W-1:0] STEP_B = OFF_W'(1);
    localparam logic [OFF_W-1:0] STEP_W = OFF_W'(2);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_rx  <= 1'b0;
            autoinc <= 1'b0;
            rd_mode <= 1'b0;
            offset  <= '0;
        end else if (ptr_we) begin
            sel_rx  <= ptr_wdata[PTR_SRC_BIT];
            autoinc <= ptr_wdata[PTR_INC_BIT];
            rd_mode <= ptr_wdata[PTR_RD_BIT];
            offset  <= ptr_wdata[OFF_W-1:0];
        end else if (adv) begin
            offset  <= offset + (adv_word ? STEP_W : STEP_B);
        end
    end
endmodule

// File: rtl/pap_addr_gen.sv
module pap_addr_gen #(
    parameter int PG_W  = 6,
    parameter int OFF_W = 11,
    parameter int AW    = PG_W + 8
) (
    input  logic              sel_rx,
    input  logic [PG_W-1:0]   rx_head_pg,
    input  logic [PG_W-1:0]   tx_pkt_pg,
    input  logic [OFF_W-1:0]  offset,
    output logic [AW-1:0]     addr
);
    logic [PG_W-1:0] page;

    always_comb begin
        page = sel_rx ? rx_head_pg : tx_pkt_pg;
        addr = {page, 8'h00} + AW'(offset);
    end
endmodule

// File: rtl/pap_rd_fsm.sv
module pap_rd_fsm
    import pap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_we,
    input  logic              ptr_rd,
    input  logic              autoinc,
    input  logic              data_re,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_re,
    output logic              rd_valid,
    output logic              consume,
    output logic [DATA_W-1:0] rd_buf
);
    pap_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        if (ptr_we) begin
            state_nx = ptr_rd ? ST_FETCH : ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  state_nx = ST_IDLE;
                ST_FETCH: state_nx = ST_WAIT;
                ST_WAIT:  state_nx = ST_HOLD;
                ST_HOLD:  state_nx = (data_re && autoinc) ? ST_FETCH : ST_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            rd_buf <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_WAIT && !ptr_we) begin
                rd_buf <= mem_rdata;
            end
        end
    end

    always_comb begin
        mem_re   = (state == ST_FETCH);
        rd_valid = (state == ST_HOLD);
        consume  = (state == ST_HOLD) && data_re && !ptr_we;
    end
endmodule

// File: rtl/pap_port.sv
module pap_port
    import pap_pkg::*;
#(
    parameter int PG_W  = 6,
    parameter int OFF_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ptr_we,
    input  logic [15:0]      ptr_wdata,
    input  logic             data_we,
    input  logic             data_re,
    input  logic             data_word,
    input  logic [15:0]      data_wdata,
    output logic [15:0]      data_rdata,
    output logic             rd_valid,
    input  logic [PG_W-1:0]  rx_head_pg,
    input  logic [PG_W-1:0]  tx_pkt_pg,
    output logic [PG_W+7:0]  mem_addr,
    output logic             mem_re,
    output logic             mem_we,
    output logic             mem_wide,
    output logic [15:0]      mem_wdata,
    input  logic [15:0]      mem_rdata
);
    localparam int AW = PG_W + 8;

    logic             sel_rx_q;
    logic             autoinc_q;
    logic             rd_mode_q;
    logic [OFF_W-1:0] offset_q;
    logic             wr_fire;
    logic             rd_consume;
    logic             adv;
    logic [15:0]      rd_buf;

    always_comb begin
        wr_fire = data_we && !rd_mode_q && !ptr_we;
        adv     = autoinc_q && (wr_fire || rd_consume);
    end

    pap_ptr_reg #(.OFF_W(OFF_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ptr_we   (ptr_we),
        .ptr_wdata(ptr_wdata),
        .adv      (adv),
        .adv_word (data_word),
        .sel_rx   (sel_rx_q),
        .autoinc  (autoinc_q),
        .rd_mode  (rd_mode_q),
        .offset   (offset_q)
    );

    pap_addr_gen #(.PG_W(PG_W), .OFF_W(OFF_W), .AW(AW)) u_addr (
        .sel_rx    (sel_rx_q),
        .rx_head_pg(rx_head_pg),
        .tx_pkt_pg (tx_pkt_pg),
        .offset    (offset_q),
        .addr      (mem_addr)
    );

    pap_rd_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ptr_we   (ptr_we),
        .ptr_rd   (ptr_wdata[PTR_RD_BIT]),
        .autoinc  (autoinc_q),
        .data_re  (data_re),
        .mem_rdata(mem_rdata),
        .mem_re   (mem_re),
        .rd_valid (rd_valid),
        .consume  (rd_consume),
        .rd_buf   (rd_buf)
    );

    always_comb begin
        mem_we     = wr_fire;
        mem_wide   = data_word;
        mem_wdata  = data_wdata;
        data_rdata = data_word ? rd_buf : {8'h00, rd_buf[7:0]};
    end
endmodule

// File: rtl/pap_port_chk.sv
module pap_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ptr_we,
    input logic        data_we,
    input logic        data_re,
    input logic        mem_re,
    input logic        mem_we,
    input logic        rd_valid,
    input logic        autoinc,
    input logic [15:0] rd_buf
);
    AST_WE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (data_we && !ptr_we && !rd_valid)); // R9

    AST_RE_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we)); // R10

    AST_VALID_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> $past(mem_re, 2)); // R6

    AST_PTR_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_we |=> !rd_valid); // R6

    AST_CONSUME_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (data_re && rd_valid && autoinc && !ptr_we) |=> !rd_valid); // R7

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(rd_valid) && !$past(ptr_we)) |-> $stable(rd_buf)); // R7
endmodule

bind pap_port pap_port_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ptr_we  (ptr_we),
    .data_we (data_we),
    .data_re (data_re),
    .mem_re  (mem_re),
    .mem_we  (mem_we),
    .rd_valid(rd_valid),
    .autoinc (autoinc_q),
    .rd_buf  (rd_buf)
);

// File: tb/pap_port_bench.sv
module pap_port_bench;
    localparam int PG_W = 4;
    localparam int AW   = PG_W + 8;
    localparam int MSZ  = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ptr_we = 1'b0;
    logic [15:0] ptr_wdata = '0;
    logic data_we = 1'b0, data_re = 1'b0, data_word = 1'b0;
    logic [15:0] data_wdata = '0;
    logic [15:0] data_rdata;
    logic rd_valid;
    logic [PG_W-1:0] rx_head_pg = '0, tx_pkt_pg = '0;
    logic [AW-1:0] mem_addr;
    logic mem_re, mem_we, mem_wide;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;

    int vectors = 0;
    int errors  = 0;
    logic [7:0] mem [0:MSZ-1];

    always #4 clk = ~clk;

    pap_port #(.PG_W(PG_W)) u_pap_port (
        .clk(clk), .rst_n(rst_n), .ptr_we(ptr_we), .ptr_wdata(ptr_wdata),
        .data_we(data_we), .data_re(data_re), .data_word(data_word),
        .data_wdata(data_wdata), .data_rdata(data_rdata), .rd_valid(rd_valid),
        .rx_head_pg(rx_head_pg), .tx_pkt_pg(tx_pkt_pg), .mem_addr(mem_addr),
        .mem_re(mem_re), .mem_we(mem_we), .mem_wide(mem_wide),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    initial begin
        for (int i = 0; i < MSZ; i++) mem[i] = 8'(i * 7 + 3);
    end

    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr] <= mem_wdata[7:0];
            if (mem_wide) mem[AW'(mem_addr + 1)] <= mem_wdata[15:8];
        end
        if (mem_re) mem_rdata <= {mem[AW'(mem_addr + 1)], mem[mem_addr]};
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] phys(input int pg, input int off);
        return AW'((pg * 256 + (off % 2048)) % MSZ);
    endfunction

    task automatic wr_ptr(input logic [15:0] v);
        @(negedge clk);
        ptr_we = 1'b1; ptr_wdata = v;
        @(negedge clk);
        ptr_we = 1'b0;
    endtask

    task automatic wait_valid(input string req);
        int n = 0;
        while (!rd_valid && n < 10) begin
            @(negedge clk);
            n++;
        end
        chk(req, 32'(rd_valid), 32'd1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R6 watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin : main
        int offs [6] = '{0, 1, 254, 255, 2046, 2047};
        int pgs  [3] = '{0, 7, 15};
        logic [15:0] vals [3];
        repeat (3) @(negedge clk);
        chk("R1 rd_valid", 32'(rd_valid), 0);
        chk("R1 mem_re",   32'(mem_re),   0);
        chk("R1 mem_we",   32'(mem_we),   0);
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep: R2 R3 R4 R5 R6 R7 R8
        for (int src = 0; src < 2; src++)
        for (int pi = 0; pi < 3; pi++)
        for (int oi = 0; oi < 6; oi++)
        for (int w = 0; w < 2; w++) begin
            int pg, off, step;
            rx_head_pg = PG_W'(pgs[pi]);
            tx_pkt_pg  = PG_W'(15 - pgs[pi]);
            pg   = src ? pgs[pi] : 15 - pgs[pi];
            off  = offs[oi];
            step = w ? 2 : 1;
            wr_ptr({src[0], 1'b1, 1'b0, 2'b00, 11'(off)});
            for (int k = 0; k < 3; k++) begin
                vals[k] = 16'(k * 4099 + off * 3 + w * 17 + src * 5 + pg);
                @(negedge clk);
                data_we = 1'b1; data_word = w[0]; data_wdata = vals[k];
                #1;
                chk("R3 mem_we", 32'(mem_we), 1);
                chk("R3 mem_wide", 32'(mem_wide), 32'(w));
                chk("R2 R4 R5 write addr", 32'(mem_addr), 32'(phys(pg, off + k * step)));
            end
            @(negedge clk);
            data_we = 1'b0;
            wr_ptr({src[0], 1'b1, 1'b1, 2'b00, 11'(off)});
            chk("R6 valid low after ptr", 32'(rd_valid), 0);
            @(negedge clk);
            chk("R6 valid low in wait", 32'(rd_valid), 0);
            @(negedge clk);
            chk("R6 valid after prefetch", 32'(rd_valid), 1);
            for (int k = 0; k < 3; k++) begin
                if (k > 0) wait_valid("R7 refetch");
                data_word = w[0];
                #1;
                chk("R6 R8 read data", 32'(data_rdata),
                    w ? 32'(vals[k]) : {24'h0, vals[k][7:0]});
                @(negedge clk);
                data_re = 1'b1;
                @(negedge clk);
                data_re = 1'b0;
                chk("R7 valid drops on consume", 32'(rd_valid), 0);
            end
        end

        // R4: no auto-increment keeps the address
        rx_head_pg = 4'd2; tx_pkt_pg = 4'd5;
        wr_ptr({1'b0, 1'b0, 1'b0, 2'b00, 11'd100});
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            data_we = 1'b1; data_word = 1'b1; data_wdata = 16'h1234 + 16'(k);
            #1;
            chk("R4 no advance addr", 32'(mem_addr), 32'(phys(5, 100)));
        end
        @(negedge clk);
        data_we = 1'b0;

        // R9: pointer write collides with data write
        wr_ptr({1'b1, 1'b1, 1'b0, 2'b00, 11'd40});
        @(negedge clk);
        ptr_we = 1'b1; ptr_wdata = {1'b1, 1'b1, 1'b0, 2'b00, 11'd200};
        data_we = 1'b1; data_word = 1'b1; data_wdata = 16'hBEEF;
        #1;
        chk("R9 no write on collision", 32'(mem_we), 0);
        @(negedge clk);
        ptr_we = 1'b0;
        #1;
        chk("R9 new offset not advanced", 32'(mem_addr), 32'(phys(2, 200)));
        @(negedge clk);
        data_we = 1'b0;

        // R7 no-increment read holds; R10 write ignored in read mode
        mem[phys(5, 300)] = 8'hA5;
        mem[AW'(phys(5, 300) + 1)] = 8'h3C;
        wr_ptr({1'b0, 1'b0, 1'b1, 2'b00, 11'd300});
        wait_valid("R6 prefetch");
        data_word = 1'b1;
        #1;
        chk("R8 word read", 32'(data_rdata), 32'h3CA5);
        @(negedge clk);
        data_re = 1'b1;
        @(negedge clk);
        data_re = 1'b0;
        chk("R7 valid stays without inc", 32'(rd_valid), 1);
        chk("R7 data held", 32'(data_rdata), 32'h3CA5);
        data_we = 1'b1; data_wdata = 16'h0F0F;
        #1;
        chk("R10 write ignored in read mode", 32'(mem_we), 0);
        @(negedge clk);
        data_we = 1'b0;
        chk("R10 memory untouched", 32'(mem[phys(5, 300)]), 32'hA5);

        // R9: pointer write collides with read consume
        data_re = 1'b1;
        ptr_we = 1'b1; ptr_wdata = {1'b0, 1'b1, 1'b1, 2'b00, 11'd300};
        @(negedge clk);
        ptr_we = 1'b0; data_re = 1'b0;
        wait_valid("R9 refetch");
        data_word = 1'b0;
        #1;
        chk("R9 read at new offset", 32'(data_rdata), 32'h00A5);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule